// File: doc/BRIEF.md
# Decoder Status Reporter

This block sits at the output side of a block error-correcting decoder. A correction engine upstream produces, for each outgoing block, a verdict (failed or not, and how many symbol errors it found) and, for each outgoing symbol, the received value and the correction pattern for that position. This block applies the pattern, or leaves the symbol untouched when the block is beyond repair. It also produces the per-block flags and the per-symbol error-location strobe with its magnitude bus. On request it replaces the first two parity symbols of the block with packed status bytes.

A block is `N_SYM` symbols long. The last `R_PAR` symbols are parity. The decoder can repair at most `R_PAR/2` symbol errors. The first symbol of each block is marked with `in_first`. A symbol is accepted on every cycle with `in_valid` high. All outputs are registered and appear one clock after the symbol they belong to, so the per-block flags change on the same edge that puts the block's first symbol on `out_sym`.

Top module: `decoder_status_report`

## Requirements
- R1: After reset `out_valid`, `err_loc`, `corr_flag` and `unc_flag` are 0, and `out_sym` and `err_mag` are all zero. Whenever `out_valid` is 0, `out_sym` is zero and `err_loc` is 0.
- R2: Each accepted symbol appears on the outputs exactly one clock later. `out_valid` equals the previous cycle's `in_valid`.
- R3: With the block's first symbol, `corr_flag` becomes 1 when the block is repairable and `blk_err_cnt` is nonzero, and 0 otherwise. The flag holds its value until the next block's first symbol.
- R4: A block is unrepairable when `blk_fail` is 1 or `blk_err_cnt` exceeds `R_PAR/2`. `unc_flag` becomes 1 with such a block's first output symbol and 0 with a repairable block's first output symbol, and holds its value in between. The two flags are never both 1.
- R5: In a repairable block, the output symbol is `in_sym` XOR `in_pat`. `err_loc` is 1 exactly when `in_pat` is nonzero, and `err_mag` equals `in_pat` in that cycle. `err_mag` is zero whenever `err_loc` is 0.
- R6: In an unrepairable block, every symbol is output unchanged and `err_loc` stays 0 for the whole block, whatever `in_pat` holds.
- R7: With `stat_en` = 1, the parity symbol at block index `N_SYM-R_PAR` is output as {F, 00, 00000}. The parity symbol at index `N_SYM-R_PAR+1` is output as {F, 00, T}, with bits written MSB first and F in bit 7. F is 1 for an unrepairable block and 0 otherwise. T is `blk_err_cnt` when F is 0 and 0 when F is 1. `err_loc` and `err_mag` at these two positions still report that position's pattern as in R5 and R6.
- R8: With `stat_en` = 0, all parity symbols, including those at the two status positions, are output as in R5 and R6.
- R9: The symbol index restarts at 0 on every `in_first` and advances only on cycles with `in_valid` high. Idle cycles inside or between blocks do not move it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stat_en | input | 1 | Replace the first two parity symbols with status bytes |
| in_valid | input | 1 | A symbol is presented this cycle |
| in_first | input | 1 | This symbol is the first of its block; qualifies the block inputs |
| in_sym | input | SYM_W | Received symbol |
| in_pat | input | SYM_W | Correction pattern for this symbol (zero means unchanged) |
| blk_fail | input | 1 | Upstream declared the block unrepairable (read with `in_first`) |
| blk_err_cnt | input | CNT_W | Number of symbol errors found in the block (read with `in_first`) |
| out_valid | output | 1 | Output symbol valid |
| out_sym | output | SYM_W | Corrected symbol, or status byte |
| err_loc | output | 1 | This output symbol was modified |
| err_mag | output | SYM_W | Correction pattern applied to this symbol |
| corr_flag | output | 1 | Current block contained corrections |
| unc_flag | output | 1 | Current block is unrepairable |

## Verification
On every cycle, the bound checker enforces the following properties:
- the one-cycle output latency;
- a zero magnitude whenever no location is flagged;
- the exclusivity of the two flags;
- a silent location strobe during unrepairable blocks;
- the raising of the unrepairable flag when the error count passes the repair limit;
- that the flags hold between block starts.

Only the bench's sweep can show that symbol values and location strobes follow the right block position. Among these cases are the exact bytes written into the two status slots and their dependence on `stat_en`. The sweep also covers patterns on parity positions and gaps between blocks.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

    // Role of the current symbol position within an outgoing block.
    typedef enum logic [1:0] {
        SLOT_PLAIN  = 2'd0,
        SLOT_STAT_A = 2'd1,
        SLOT_STAT_B = 2'd2
    } slot_e;

endpackage

// File: rtl/dsr_pos_track.sv
module dsr_pos_track
    import dsr_pkg::*;
#(
    parameter int N_SYM = 16,
    parameter int R_PAR = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in_valid,
    input  logic  in_first,
    output slot_e slot
);
    localparam int POS_W = $clog2(N_SYM + 1);
    localparam logic [POS_W-1:0] PAR0 = POS_W'(N_SYM - R_PAR);
    localparam logic [POS_W-1:0] PAR1 = POS_W'(N_SYM - R_PAR + 1);

    logic [POS_W-1:0] pos_d, pos_q;
    logic [POS_W-1:0] idx;

    always_comb begin
        idx   = in_first ? '0 : pos_q;
        pos_d = in_valid ? idx + POS_W'(1) : pos_q;
        if (idx == PAR0)      slot = SLOT_STAT_A;
        else if (idx == PAR1) slot = SLOT_STAT_B;
        else                  slot = SLOT_PLAIN;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end
endmodule

// File: rtl/dsr_stat_pack.sv
module dsr_stat_pack #(
    parameter int SYM_W = 8,
    parameter int CNT_W = 5
) (
    input  logic             fail,
    input  logic [CNT_W-1:0] cnt,
    output logic [SYM_W-1:0] byte_a,
    output logic [SYM_W-1:0] byte_b
);
    localparam int PAD_W = SYM_W - 1 - CNT_W;

    always_comb begin
        byte_a = {fail, PAD_W'(0), CNT_W'(0)};
        byte_b = {fail, PAD_W'(0), (fail ? CNT_W'(0) : cnt)};
    end
endmodule

// File: rtl/dsr_sym_fix.sv
module dsr_sym_fix #(
    parameter int SYM_W = 8
) (
    input  logic             blk_ok,
    input  logic [SYM_W-1:0] sym,
    input  logic [SYM_W-1:0] pat,
    output logic [SYM_W-1:0] fixed,
    output logic             loc,
    output logic [SYM_W-1:0] mag
);
    always_comb begin
        loc   = blk_ok && (pat != '0);
        mag   = loc ? pat : '0;
        fixed = sym ^ mag;
    end
endmodule

// File: rtl/decoder_status_report.sv
module decoder_status_report
    import dsr_pkg::*;
#(
    parameter int N_SYM = 16,
    parameter int R_PAR = 4,
    parameter int SYM_W = 8,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stat_en,
    input  logic             in_valid,
    input  logic             in_first,
    input  logic [SYM_W-1:0] in_sym,
    input  logic [SYM_W-1:0] in_pat,
    input  logic             blk_fail,
    input  logic [CNT_W-1:0] blk_err_cnt,
    output logic             out_valid,
    output logic [SYM_W-1:0] out_sym,
    output logic             err_loc,
    output logic [SYM_W-1:0] err_mag,
    output logic             corr_flag,
    output logic             unc_flag
);
    localparam logic [CNT_W-1:0] T_CAP = CNT_W'(R_PAR / 2);

    typedef struct packed {
        logic             out_valid;
        logic [SYM_W-1:0] out_sym;
        logic             loc;
        logic [SYM_W-1:0] mag;
        logic             corr;
        logic             unc;
        logic             blk_ok;
        logic [CNT_W-1:0] blk_cnt;
    } state_t;

    state_t s_d, s_q;

    slot_e            slot;
    logic             start;
    logic             ok_now;
    logic [CNT_W-1:0] cnt_now;
    logic [SYM_W-1:0] fixed, mag, stat_a, stat_b;
    logic             loc;

    dsr_pos_track #(.N_SYM(N_SYM), .R_PAR(R_PAR)) u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_first (in_first),
        .slot     (slot)
    );

    dsr_sym_fix #(.SYM_W(SYM_W)) u_fix (
        .blk_ok (ok_now),
        .sym    (in_sym),
        .pat    (in_pat),
        .fixed  (fixed),
        .loc    (loc),
        .mag    (mag)
    );

    dsr_stat_pack #(.SYM_W(SYM_W), .CNT_W(CNT_W)) u_pack (
        .fail   (!ok_now),
        .cnt    (cnt_now),
        .byte_a (stat_a),
        .byte_b (stat_b)
    );

    always_comb begin
        start   = in_valid && in_first;
        ok_now  = start ? (!blk_fail && (blk_err_cnt <= T_CAP)) : s_q.blk_ok;
        cnt_now = start ? blk_err_cnt : s_q.blk_cnt;

        s_d           = s_q;
        s_d.out_valid = in_valid;
        s_d.out_sym   = '0;
        s_d.loc       = 1'b0;
        s_d.mag       = '0;

        if (start) begin
            s_d.blk_ok  = ok_now;
            s_d.blk_cnt = cnt_now;
            s_d.corr    = ok_now && (cnt_now != '0);
            s_d.unc     = !ok_now;
        end

        if (in_valid) begin
            s_d.loc = loc;
            s_d.mag = mag;
            if (stat_en && slot == SLOT_STAT_A)      s_d.out_sym = stat_a;
            else if (stat_en && slot == SLOT_STAT_B) s_d.out_sym = stat_b;
            else                                     s_d.out_sym = fixed;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid = s_q.out_valid;
    assign out_sym   = s_q.out_sym;
    assign err_loc   = s_q.loc;
    assign err_mag   = s_q.mag;
    assign corr_flag = s_q.corr;
    assign unc_flag  = s_q.unc;
endmodule

// File: rtl/dsr_checker.sv
module dsr_checker #(
    parameter int R_PAR = 4,
    parameter int SYM_W = 8,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_first,
    input logic             blk_fail,
    input logic [CNT_W-1:0] blk_err_cnt,
    input logic             out_valid,
    input logic [SYM_W-1:0] out_sym,
    input logic             err_loc,
    input logic [SYM_W-1:0] err_mag,
    input logic             corr_flag,
    input logic             unc_flag
);
    localparam logic [CNT_W-1:0] T_CAP = CNT_W'(R_PAR / 2);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_sym == '0 && !err_loc));

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_no_phantom_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_flag_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_first) |=> ($stable(corr_flag) && $stable(unc_flag)));

    p_flags_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(corr_flag && unc_flag));

    p_over_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_first && (blk_fail || blk_err_cnt > T_CAP)) |=> unc_flag);

    p_mag_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !err_loc |-> err_mag == '0);

    p_loc_real_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_loc |-> (out_valid && err_mag != '0));

    p_unc_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        unc_flag |-> !err_loc);
endmodule

bind decoder_status_report dsr_checker #(
    .R_PAR (R_PAR),
    .SYM_W (SYM_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_first    (in_first),
    .blk_fail    (blk_fail),
    .blk_err_cnt (blk_err_cnt),
    .out_valid   (out_valid),
    .out_sym     (out_sym),
    .err_loc     (err_loc),
    .err_mag     (err_mag),
    .corr_flag   (corr_flag),
    .unc_flag    (unc_flag)
);

// File: tb/tb_decoder_status_report.sv
module tb_decoder_status_report;
    localparam int N = 16;
    localparam int R = 4;
    localparam int K = N - R;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stat_en = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_first = 1'b0;
    logic [7:0] in_sym = '0;
    logic [7:0] in_pat = '0;
    logic       blk_fail = 1'b0;
    logic [4:0] blk_err_cnt = '0;
    logic       out_valid, err_loc, corr_flag, unc_flag;
    logic [7:0] out_sym, err_mag;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    decoder_status_report #(.N_SYM(N), .R_PAR(R), .SYM_W(8), .CNT_W(5)) dut (
        .clk(clk), .rst_n(rst_n), .stat_en(stat_en),
        .in_valid(in_valid), .in_first(in_first), .in_sym(in_sym),
        .in_pat(in_pat), .blk_fail(blk_fail), .blk_err_cnt(blk_err_cnt),
        .out_valid(out_valid), .out_sym(out_sym), .err_loc(err_loc),
        .err_mag(err_mag), .corr_flag(corr_flag), .unc_flag(unc_flag)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired act=%0d exp=<20000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic run_block(input int b, input bit fail, input int cnt,
                             input bit sen, input bit mid_gap);
        logic [7:0] pat [N];
        bit ok;
        int exp_sym;
        logic [7:0] d;
        ok = !fail && (cnt <= R / 2);
        for (int i = 0; i < N; i++) pat[i] = '0;
        for (int k = 0; k < cnt; k++)
            pat[(k * 5 + b) % N] = 8'(((k * 29 + b * 3) % 255) + 1);
        stat_en = sen;
        for (int i = 0; i < N; i++) begin
            d = 8'((i * 37 + b * 11) & 8'hFF);
            in_valid    = 1'b1;
            in_first    = (i == 0);
            in_sym      = d;
            in_pat      = pat[i];
            blk_fail    = (i == 0) ? fail : 1'b0;
            blk_err_cnt = (i == 0) ? 5'(cnt) : 5'd0;
            @(negedge clk);
            if (sen && i == K)          exp_sym = {!ok, 7'b0};
            else if (sen && i == K + 1) exp_sym = {!ok, 2'b00, (ok ? 5'(cnt) : 5'd0)};
            else if (ok)                exp_sym = d ^ pat[i];
            else                        exp_sym = d;
            if (sen && (i == K || i == K + 1)) check("R7 status byte", out_sym, exp_sym);
            else if (i >= K)                   check("R8 parity symbol", out_sym, exp_sym);
            else if (ok)                       check("R5 data symbol", out_sym, exp_sym);
            else                               check("R6 data unchanged", out_sym, exp_sym);
            check("R2 out_valid", out_valid, 1);
            check(ok ? "R5 err_loc" : "R6 err_loc", err_loc, (ok && pat[i] != 0));
            check("R5 err_mag", err_mag, (ok ? pat[i] : 0));
            check("R3 corr_flag", corr_flag, (ok && cnt != 0));
            check("R4 unc_flag", unc_flag, !ok);
            if (mid_gap && i == 5) begin
                in_valid = 1'b0;
                in_first = 1'b0;
                @(negedge clk);
                check("R9 idle mid-block out_valid", out_valid, 0);
                check("R1 idle out_sym", out_sym, 0);
            end
        end
        in_valid = 1'b0;
        in_first = 1'b0;
        in_pat   = 8'hFF;
        @(negedge clk);
        check("R2 gap out_valid", out_valid, 0);
        check("R1 gap err_loc", err_loc, 0);
        check("R3 corr held", corr_flag, (ok && cnt != 0));
        check("R4 unc held", unc_flag, !ok);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        check("R1 reset out_valid", out_valid, 0);
        check("R1 reset out_sym", out_sym, 0);
        check("R1 reset err_loc", err_loc, 0);
        check("R1 reset err_mag", err_mag, 0);
        check("R1 reset corr", corr_flag, 0);
        check("R1 reset unc", unc_flag, 0);
        rst_n = 1'b1;
        @(negedge clk);
        begin
            int b;
            b = 0;
            for (int f = 0; f < 2; f++)
                for (int c = 0; c <= 5; c++)
                    for (int s = 0; s < 2; s++) begin
                        run_block(b, f[0], c, s[0], (b % 3) == 1);
                        b++;
                    end
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule